// File: doc/BRIEF.md
# Binary BCH Error-Locator Solver

This block takes the 2t syndromes of a binary BCH codeword and computes the error-locator polynomial sigma(x) together with its degree. It uses a row-table form of the binary Berlekamp iteration: every pass moves the step index on by two, and a table keeps one candidate polynomial per row along with that row's degree, discrepancy and delta. When the discrepancy is nonzero, the update draws on the earlier row with the largest delta. When the discrepancy is zero, the row is copied forward. After a counted run of zero discrepancies the solver stops early.

A caller presents the syndromes, the strength t and a field select, then pulses `start`. The block raises `busy`, works through up to t steps and signals the result with a one-cycle `done` pulse. It holds the coefficients and the degree on its outputs until the next accepted start. Syndrome generation comes before this block and the root search comes after it; neither is part of it.

Top module: `bch_sigma_solver`

## Requirements
- R1: While reset is asserted and after its release, `busy` and `done` are 0, and `sigma_o` and `deg_o` are 0.
- R2: `fsel`=0 selects GF(2^13) with the primitive polynomial 0x201b, and `fsel`=1 selects GF(2^14) with 0x4443. Every field element is in polynomial basis with bit 0 as the x^0 term.
- R3: A `start` seen while idle captures `fsel`, `t_i` and `syn_i` and raises `busy` on the next cycle. A `start` seen while busy is ignored and does not change the result.
- R4: `done` is high for exactly one cycle. `busy` is low in that cycle. `sigma_o` and `deg_o` stay unchanged from then on until a new start.
- R5: At `done`, coefficient 0 of `sigma_o` equals 1.
- R6: For v distinct error locators X_j = alpha^e_j with v <= t, where syndrome S_k sits at `syn_i[(k-1)*14 +: 14]`, the result is sigma(x) = product of (1 + X_j x), with coefficient k at `sigma_o[k*14 +: 14]`, and `deg_o` = v <= t.
- R7: An all-zero syndrome set gives sigma = 1 and `deg_o` = 0.
- R8: Every coefficient above `deg_o` is zero at `done`.
- R9: Let r = t - 1 - deg. A zero discrepancy increments a counter, and the solver exits once that counter reaches floor(r/2) + 2 when r is odd, or floor(r/2) + 1 when r is even. For all-zero syndromes this makes `done` rise 2z-1 cycles after the edge that accepts `start`, where z is that threshold with deg = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a solve when idle |
| fsel | input | 1 | Field select: 0 = GF(2^13), 1 = GF(2^14) |
| t_i | input | TW | Correction strength t, 1..TMAX |
| syn_i | input | 2*TMAX*14 | Syndromes S1..S2TMAX, S1 in the low bits |
| busy | output | 1 | Solve in progress |
| done | output | 1 | One-cycle result strobe |
| sigma_o | output | (TMAX+1)*14 | Locator coefficients, coefficient 0 in the low bits |
| deg_o | output | TW | Degree of the locator |

## Verification
The assertions check the handshake on every cycle. They cover the one-cycle `done`, `busy` being low in that cycle, the outputs holding while idle, a unit constant term, the zero upper coefficients and a degree no larger than t. Only the bench's scenarios can show that the polynomial is right. The bench builds syndromes from known error positions in both fields and compares the result with the product of the locator factors. Its scenarios also show that the early-exit threshold gives the expected latency for each strength and that a start arriving mid-solve leaves the result untouched.

// File: rtl/bch_sigma_solver.sv
module bch_sigma_solver #(
  parameter int TMAX = 4,
  parameter int TW   = $clog2(TMAX + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       fsel,
  input  logic [TW-1:0]              t_i,
  input  logic [2*TMAX*14-1:0]       syn_i,
  output logic                       busy,
  output logic                       done,
  output logic [(TMAX+1)*14-1:0]     sigma_o,
  output logic [TW-1:0]              deg_o
);
  localparam int W  = 14;
  localparam int NR = TMAX + 2;
  localparam int NC = TMAX + 1;
  localparam int NS = 2 * TMAX;
  localparam int IW = $clog2(NR);
  localparam logic [W:0] POLY13 = 15'h201b;
  localparam logic [W:0] POLY14 = 15'h4443;

  typedef enum logic [2:0] {IDLE, STEP, INV, UPD, DISC} st_t;

  st_t            st;
  logic [W-1:0]   sg [NR][NC];
  logic [TW-1:0]  dg [NR];
  logic [W-1:0]   dc [NR];
  logic [W-1:0]   sy [1:NS];
  logic [TW-1:0]  tq;
  logic           fq;
  logic [IW-1:0]  ix, ro_q, zc, ro_c, nx;
  logic [W-1:0]   acc, sq, q, nd;
  logic [3:0]     cnt;
  logic [W-1:0]   nrow [NC];
  logic [TW-1:0]  ndeg;
  logic           thr_hit;

  function automatic logic [W-1:0] gmul(input logic [W-1:0] a, input logic [W-1:0] b, input logic f);
    logic [W:0] p;
    p = '0;
    for (int j = W - 1; j >= 0; j--) begin
      p = {p[W-1:0], 1'b0};
      if (f ? p[W] : p[W-1]) p = p ^ (f ? POLY14 : POLY13);
      if (b[j]) p = p ^ {1'b0, a};
    end
    return p[W-1:0];
  endfunction

  assign busy = (st != IDLE);
  assign nx   = ix + 1'b1;

  always_comb begin
    int best, dlt, diff, mur, dmax, base, rem, thr;
    ro_c = '0;
    best = -1;
    for (int j = 1; j < NR; j++) begin
      dlt = 2 * (j - 1) - int'(dg[j]);
      if (j < int'(ix) && dc[j] != '0 && dlt > best) begin
        best = dlt;
        ro_c = IW'(j);
      end
    end
    mur  = (ro_q == '0) ? -1 : 2 * (int'(ro_q) - 1);
    diff = 2 * (int'(ix) - 1) - mur;
    q    = gmul(dc[ix], acc, fq);
    for (int k = 0; k < NC; k++) begin
      nrow[k] = sg[ix][k];
      if (k >= diff) nrow[k] = nrow[k] ^ gmul(q, sg[ro_q][k - diff], fq);
    end
    dmax = int'(dg[ro_q]) + diff;
    if (int'(dg[ix]) > dmax) dmax = int'(dg[ix]);
    if (dmax > TMAX) dmax = TMAX;
    ndeg = dmax[TW-1:0];
    base = 2 * int'(ix) + 1;
    nd   = (base <= NS) ? sy[base] : '0;
    for (int k = 1; k <= TMAX; k++)
      if (k <= int'(dg[nx]) && base - k >= 1 && base - k <= NS)
        nd = nd ^ gmul(sg[nx][k], sy[base - k], fq);
    rem = int'(tq) - int'(dg[ix]) - 1;
    thr = rem / 2 + (rem[0] ? 2 : 1);
    thr_hit = (rem >= 0) && (int'(zc) + 1 == thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; done <= 1'b0; sigma_o <= '0; deg_o <= '0;
      tq <= '0; fq <= 1'b0; ix <= '0; ro_q <= '0; zc <= '0;
      acc <= '0; sq <= '0; cnt <= '0;
      for (int r = 0; r < NR; r++) begin
        dg[r] <= '0; dc[r] <= '0;
        for (int c = 0; c < NC; c++) sg[r][c] <= '0;
      end
      for (int k = 1; k <= NS; k++) sy[k] <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          fq <= fsel; tq <= t_i;
          for (int k = 1; k <= NS; k++) sy[k] <= syn_i[(k-1)*W +: W];
          for (int r = 0; r < NR; r++) begin
            dg[r] <= '0; dc[r] <= '0;
            for (int c = 0; c < NC; c++) sg[r][c] <= '0;
          end
          sg[0][0] <= W'(1); sg[1][0] <= W'(1);
          dc[0] <= W'(1); dc[1] <= syn_i[W-1:0];
          ix <= IW'(1); zc <= '0;
          st <= STEP;
        end
        STEP: if (dc[ix] == '0) begin
          zc <= zc + 1'b1;
          if (thr_hit) begin
            for (int c = 0; c < NC; c++) sigma_o[c*W +: W] <= sg[ix][c];
            deg_o <= dg[ix]; done <= 1'b1; st <= IDLE;
          end else begin
            sg[nx] <= sg[ix]; dg[nx] <= dg[ix]; st <= DISC;
          end
        end else begin
          ro_q <= ro_c;
          sq <= gmul(dc[ro_c], dc[ro_c], fq);
          acc <= W'(1); cnt <= '0; st <= INV;
        end
        INV: begin
          acc <= gmul(acc, sq, fq);
          sq  <= gmul(sq, sq, fq);
          cnt <= cnt + 1'b1;
          if (cnt == (fq ? 4'd12 : 4'd11)) st <= UPD;
        end
        UPD: begin
          sg[nx] <= nrow; dg[nx] <= ndeg; st <= DISC;
        end
        DISC: if (ix == IW'(tq)) begin
          for (int c = 0; c < NC; c++) sigma_o[c*W +: W] <= sg[nx][c];
          deg_o <= dg[nx]; done <= 1'b1; st <= IDLE;
        end else begin
          dc[nx] <= nd; ix <= nx; st <= STEP;
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r3_start_takes: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy);
  a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r4_done_idle:   assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r4_hold_idle:   assert property (@(posedge clk) disable iff (!rst_n)
                      (!busy && !start) |=> ($stable(sigma_o) && $stable(deg_o)));
  a_r5_unit_const:  assert property (@(posedge clk) disable iff (!rst_n) done |-> (sigma_o[W-1:0] == W'(1)));
  a_r6_deg_bound:   assert property (@(posedge clk) disable iff (!rst_n) done |-> (deg_o <= tq));
  for (genvar k = 1; k <= TMAX; k++) begin : g_r8
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
                       (done && int'(deg_o) < k) |-> (sigma_o[k*W +: W] == '0));
  end
endmodule

// File: tb/bch_sigma_solver_tb.sv
module bch_sigma_solver_tb;
  localparam int T  = 4;
  localparam int W  = 14;
  localparam int TW = $clog2(T + 1);

  logic                 clk = 1'b0, rst_n = 1'b0, start = 1'b0, fsel = 1'b0;
  logic [TW-1:0]        t_i = '0;
  logic [2*T*W-1:0]     syn_i = '0;
  logic                 busy, done;
  logic [(T+1)*W-1:0]   sigma_o;
  logic [TW-1:0]        deg_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  bch_sigma_solver #(.TMAX(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .fsel(fsel), .t_i(t_i),
    .syn_i(syn_i), .busy(busy), .done(done), .sigma_o(sigma_o), .deg_o(deg_o));

  // {fsel, t, nerr, e3, e2, e1, e0}
  localparam logic [62:0] VEC [10] = '{
    {1'b0, 3'd4, 3'd1, 14'd0,  14'd0,    14'd0,     14'd5},
    {1'b0, 3'd4, 3'd2, 14'd0,  14'd0,    14'd100,   14'd0},
    {1'b0, 3'd4, 3'd3, 14'd0,  14'd8000, 14'd1000,  14'd7},
    {1'b0, 3'd4, 3'd4, 14'd4,  14'd3,    14'd2,     14'd1},
    {1'b1, 3'd4, 3'd4, 14'd42, 14'd9999, 14'd3,     14'd16000},
    {1'b1, 3'd2, 3'd2, 14'd0,  14'd0,    14'd20,    14'd10},
    {1'b1, 3'd3, 3'd1, 14'd0,  14'd0,    14'd0,     14'd16382},
    {1'b0, 3'd1, 3'd1, 14'd0,  14'd0,    14'd0,     14'd8190},
    {1'b1, 3'd4, 3'd3, 14'd0,  14'd500,  14'd16001, 14'd2},
    {1'b1, 3'd3, 3'd2, 14'd0,  14'd0,    14'd1,     14'd0}
  };

  function automatic logic [W-1:0] bx(input logic [W-1:0] a, input logic f);
    logic [W:0] p;
    p = {a, 1'b0};
    if (f ? p[W] : p[W-1]) p = p ^ (f ? 15'h4443 : 15'h201b);
    return p[W-1:0];
  endfunction

  function automatic logic [W-1:0] bmul(input logic [W-1:0] a, input logic [W-1:0] b, input logic f);
    logic [W-1:0] r, cur;
    r = '0; cur = a;
    for (int j = 0; j < W; j++) begin
      if (b[j]) r = r ^ cur;
      cur = bx(cur, f);
    end
    return r;
  endfunction

  function automatic logic [W-1:0] bpow(input int e, input logic f);
    logic [W-1:0] r;
    r = 1;
    for (int i = 0; i < e; i++) r = bx(r, f);
    return r;
  endfunction

  task automatic make(input logic f, input int n, input logic [4*W-1:0] ev,
                      output logic [2*T*W-1:0] syn, output logic [(T+1)*W-1:0] sig);
    logic [W-1:0] x, p;
    syn = '0; sig = '0; sig[W-1:0] = 1;
    for (int j = 0; j < n; j++) begin
      x = bpow(int'(ev[j*W +: W]), f);
      for (int k = T; k >= 1; k--) sig[k*W +: W] = sig[k*W +: W] ^ bmul(x, sig[(k-1)*W +: W], f);
      p = x;
      for (int k = 1; k <= 2*T; k++) begin
        syn[(k-1)*W +: W] = syn[(k-1)*W +: W] ^ p;
        p = bmul(p, x, f);
      end
    end
  endtask

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin n_bad++; $display("FAIL %s", msg); end
  endtask

  task automatic run(input logic f, input int t, input logic [2*T*W-1:0] s, output int lat);
    @(negedge clk);
    fsel = f; t_i = TW'(t); syn_i = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 0;
    while (!done && lat < 2000) begin @(negedge clk); lat++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [2*T*W-1:0] s, s2;
    logic [(T+1)*W-1:0] e, e2, held;
    int lat, z, r;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && sigma_o == '0 && deg_o == '0,
        $sformatf("R1 in reset busy=%0d done=%0d deg=%0d exp 0", busy, done, deg_o));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && done == 0 && sigma_o == '0 && deg_o == '0,
        $sformatf("R1 after reset busy=%0d done=%0d sigma=%h exp 0", busy, done, sigma_o));

    for (int v = 0; v < 10; v++) begin
      make(VEC[v][62], int'(VEC[v][58:56]), VEC[v][55:0], s, e);
      run(VEC[v][62], int'(VEC[v][61:59]), s, lat);
      chk(done == 1, $sformatf("R4 vec %0d done seen=%0d exp 1", v, done));
      chk(sigma_o == e, $sformatf("R2/R6/R8 vec %0d sigma=%h exp %h", v, sigma_o, e));
      chk(int'(deg_o) == int'(VEC[v][58:56]), $sformatf("R6 vec %0d deg=%0d exp %0d", v, deg_o, VEC[v][58:56]));
      chk(sigma_o[W-1:0] == 1, $sformatf("R5 vec %0d s0=%h exp 1", v, sigma_o[W-1:0]));
      chk(busy == 0, $sformatf("R4 vec %0d busy=%0d exp 0", v, busy));
      @(negedge clk);
      chk(done == 0, $sformatf("R4 vec %0d done width, done=%0d exp 0", v, done));
    end

    for (int t = 1; t <= T; t++) begin
      r = t - 1;
      z = r / 2 + ((r % 2 == 1) ? 2 : 1);
      run(1'b0, t, '0, lat);
      chk(sigma_o == {{(T*W){1'b0}}, 14'd1} && deg_o == 0,
          $sformatf("R7 t=%0d sigma=%h deg=%0d exp 1,0", t, sigma_o, deg_o));
      chk(lat == 2*z - 1, $sformatf("R9 t=%0d latency=%0d exp %0d", t, lat, 2*z - 1));
    end

    make(1'b0, 4, VEC[3][55:0], s, e);
    make(1'b1, 1, VEC[6][55:0], s2, e2);
    @(negedge clk);
    fsel = 1'b0; t_i = TW'(4); syn_i = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 1, $sformatf("R3 busy mid-run=%0d exp 1", busy));
    fsel = 1'b1; t_i = TW'(3); syn_i = s2; start = 1'b1;
    @(negedge clk);
    start = 1'b0; lat = 0;
    while (!done && lat < 2000) begin @(negedge clk); lat++; end
    chk(sigma_o == e && deg_o == 4, $sformatf("R3 ignored start sigma=%h exp %h", sigma_o, e));

    held = sigma_o;
    syn_i = s2; t_i = TW'(1); fsel = 1'b1;
    repeat (6) @(negedge clk);
    chk(sigma_o == held && deg_o == 4 && done == 0,
        $sformatf("R4 hold sigma=%h deg=%0d exp %h,4", sigma_o, deg_o, held));

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule